// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block collects up to 32 interrupt sources into a single request line for a processor. Each source is brought into the clock domain through a synchroniser and then latched into a status word. A build-time mask chooses how each bit is latched. A level source sets its status bit on every cycle that it is high. An edge source sets its bit once, when it rises, and the bit stays set until software clears it.

The status word is ANDed with an enable word to form the pending word. The lowest-numbered pending source is presented as a vector number. Software reaches all state through eight 32-bit word registers on a simple synchronous bus. One register clears status bits, and two registers set or clear enable bits without a read-modify-write. A two-bit master control register has two bits. One bit gates the request line. The other turns hardware latching on and off. While hardware latching is off, the status word is writable.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0 except the vector word (index 6), which reads 0xFFFFFFFF. The request line `irq_req` is low.
- R2: A source whose bit in `EDGE_SEL` is 0 is level-sensitive. While master bit 1 is set, its status bit is set on every cycle in which its synchronised input is high. An input held from one falling edge of the clock is latched on the third following rising edge, because two synchroniser flops come first.
- R3: A source whose bit in `EDGE_SEL` is 1 is edge-sensitive. While master bit 1 is set, a rising edge of its synchronised input sets its status bit. The bit stays set after the input falls, until it is acknowledged.
- R4: The pending word (index 1) always reads status AND enable. Bus writes to the pending word and to the vector word (index 6) have no effect.
- R5: The vector word (index 6) holds the index of the lowest set pending bit. When no bit is pending, it reads 0xFFFFFFFF.
- R6: A write to the acknowledge word (index 3) clears each status bit that is written as 1. If a latch event and an acknowledge hit the same bit in the same cycle, the latch wins and the bit stays set.
- R7: A write to the set-enable word (index 4) ORs the data into enable. A write to the clear-enable word (index 5) clears each enable bit written as 1. A read of index 3, 4 or 5 returns the value last written there.
- R8: A write to the master word (index 7) keeps only data bits [1:0]. `irq_req` is a register. It goes high one cycle after master bit 0 is 1 and the pending word is non-zero, and it goes low one cycle after that stops being true.
- R9: A write to the status word (index 0) is ignored while master bit 1 is set. While master bit 1 is clear, the write replaces the whole status word.
- R10: While master bit 1 is clear, no input changes the status word.
- R11: The byte address selects word index `bus_addr[4:2]`. A read is registered: `bus_rd_data` shows the selected word one cycle after `bus_rd_en` and holds that value until the next read. All register logic uses the state held before the current clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N_SRC | Asynchronous interrupt sources |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | DATA_W | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Two things can touch the same status bit in one cycle: hardware latching and a software acknowledge. When they meet, the latch must win. The bench holds a level source high while it acknowledges that source. It also times an edge source so that its synchronised rise falls in the same cycle as the acknowledge write. A long random phase then mixes input toggles with bus traffic to every address. A behavioural model, stepped on every rising edge, predicts the request line and the read data. Both are compared at every falling edge, so any cycle in which an acknowledge beats a latch event shows up as a mismatch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word index of each register; software depends on this order.
  typedef enum logic [2:0] {
    RI_STATUS = 3'd0,
    RI_PEND   = 3'd1,
    RI_ENABLE = 3'd2,
    RI_ACK    = 3'd3,
    RI_SETEN  = 3'd4,
    RI_CLREN  = 3'd5,
    RI_VECTOR = 3'd6,
    RI_MASTER = 3'd7
  } reg_idx_e;

  localparam int unsigned MASTER_W   = 2;
  localparam int unsigned MB_REQ_EN  = 0;
  localparam int unsigned MB_HW_EN   = 1;
  localparam int unsigned WORD_LSB   = 2;
  localparam int unsigned IDX_W      = 3;

endpackage

// File: rtl/irqc_input_sync.sv
module irqc_input_sync #(
  parameter int unsigned      N_SRC       = 32,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [N_SRC-1:0] EDGE_SEL    = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  output logic [N_SRC-1:0] hit
);

  logic [N_SRC-1:0] stage_q [SYNC_STAGES];
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= irq_in;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign synced = stage_q[SYNC_STAGES-1];

  for (genvar b = 0; b < N_SRC; b++) begin : g_kind
    if (EDGE_SEL[b]) begin : g_edge
      assign hit[b] = synced[b] & ~prev_q[b];
    end else begin : g_level
      assign hit[b] = synced[b];
    end
  end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [N_SRC-1:0]  pend,
  output logic [DATA_W-1:0] vector,
  output logic              any
);

  localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IW-1:0] idx;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  assign vector = any ? DATA_W'(idx) : '1;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned      N_SRC       = 32,
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      ADDR_W      = 5,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [N_SRC-1:0] EDGE_SEL    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              irq_req
);

  localparam int unsigned IDX_HI = WORD_LSB + IDX_W - 1;

  logic [N_SRC-1:0]    status_q, status_nxt;
  logic [N_SRC-1:0]    enable_q, enable_nxt;
  logic [N_SRC-1:0]    ack_q, seten_q, clren_q;
  logic [MASTER_W-1:0] mer_q;
  logic [N_SRC-1:0]    hits, pend;
  logic [DATA_W-1:0]   vector;
  logic                pend_any;
  logic [DATA_W-1:0]   rd_q, rd_word;
  logic                req_q;
  logic                addr_ok, wr_hit;
  logic [IDX_W-1:0]    wr_idx;
  reg_idx_e            sel;
  logic [N_SRC-1:0]    wdat;
  logic                unused_bits;

  assign unused_bits = ^{bus_addr[WORD_LSB-1:0], bus_wr_data};

  if (ADDR_W > IDX_HI + 1) begin : g_addr_hi
    assign addr_ok = (bus_addr[ADDR_W-1:IDX_HI+1] == '0);
  end else begin : g_addr_exact
    assign addr_ok = 1'b1;
  end

  assign wr_idx = bus_addr[IDX_HI:WORD_LSB];
  assign sel    = reg_idx_e'(wr_idx);
  assign wr_hit = bus_wr_en & addr_ok;
  assign wdat   = bus_wr_data[N_SRC-1:0];

  irqc_input_sync #(
    .N_SRC      (N_SRC),
    .SYNC_STAGES(SYNC_STAGES),
    .EDGE_SEL   (EDGE_SEL)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .irq_in(irq_in),
    .hit   (hits)
  );

  assign pend = status_q & enable_q;

  irqc_prio_enc #(
    .N_SRC (N_SRC),
    .DATA_W(DATA_W)
  ) u_enc (
    .pend  (pend),
    .vector(vector),
    .any   (pend_any)
  );

  // Status: software edits first, then hardware latching ORs on top.
  always_comb begin
    status_nxt = status_q;
    if (wr_hit && sel == RI_STATUS && !mer_q[MB_HW_EN]) status_nxt = wdat;
    if (wr_hit && sel == RI_ACK) status_nxt = status_nxt & ~wdat;
    if (mer_q[MB_HW_EN]) status_nxt = status_nxt | hits;
  end

  always_comb begin
    enable_nxt = enable_q;
    if (wr_hit) begin
      case (sel)
        RI_ENABLE: enable_nxt = wdat;
        RI_SETEN:  enable_nxt = enable_q | wdat;
        RI_CLREN:  enable_nxt = enable_q & ~wdat;
        default:   enable_nxt = enable_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      ack_q    <= '0;
      seten_q  <= '0;
      clren_q  <= '0;
      mer_q    <= '0;
      req_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      enable_q <= enable_nxt;
      req_q    <= mer_q[MB_REQ_EN] & pend_any;
      if (wr_hit) begin
        case (sel)
          RI_ACK:    ack_q   <= wdat;
          RI_SETEN:  seten_q <= wdat;
          RI_CLREN:  clren_q <= wdat;
          RI_MASTER: mer_q   <= bus_wr_data[MASTER_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr_ok) begin
      case (sel)
        RI_STATUS: rd_word = DATA_W'(status_q);
        RI_PEND:   rd_word = DATA_W'(pend);
        RI_ENABLE: rd_word = DATA_W'(enable_q);
        RI_ACK:    rd_word = DATA_W'(ack_q);
        RI_SETEN:  rd_word = DATA_W'(seten_q);
        RI_CLREN:  rd_word = DATA_W'(clren_q);
        RI_VECTOR: rd_word = vector;
        RI_MASTER: rd_word = DATA_W'(mer_q);
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (bus_rd_en) rd_q <= rd_word;
  end

  assign bus_rd_data = rd_q;
  assign irq_req     = req_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic [1:0]        mer_q,
  input logic [DATA_W-1:0] vector,
  input logic              wr_hit,
  input logic [2:0]        wr_idx,
  input logic              irq_req
);

  logic [N_SRC-1:0] pend_c;
  assign pend_c = status_q & enable_q;

  assert_reset_req_R1: assert property (@(posedge clk) $fell(rst) |-> !irq_req);

  assert_req_cause_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(mer_q[0]) && $past(pend_c != '0)));

  assert_vec_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_c == '0) |-> (vector == '1));

  assert_vec_lowest_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_c != '0) |-> (pend_c[vector[$clog2(N_SRC)-1:0]] &&
                        ((pend_c & ~({N_SRC{1'b1}} << vector)) == '0)));

  assert_sw_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (mer_q[1] && wr_hit && wr_idx == 3'd0) |=> ((~status_q & $past(status_q)) == '0));

  assert_no_hw_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (!mer_q[1] && !(wr_hit && wr_idx == 3'd0)) |=> ((status_q & ~$past(status_q)) == '0));

endmodule

bind irq_vec_ctrl irqc_checker #(
  .N_SRC (N_SRC),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .status_q(status_q),
  .enable_q(enable_q),
  .mer_q   (mer_q),
  .vector  (vector),
  .wr_hit  (wr_hit),
  .wr_idx  (wr_idx),
  .irq_req (irq_req)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;

  localparam logic [31:0] EDGE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rd_data;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  irq_vec_ctrl #(.EDGE_SEL(EDGE)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .irq_req(irq_req)
  );

  // Behavioural reference model
  logic [31:0] m_s1, m_s2, m_prev, m_st, m_en, m_ack, m_sen, m_cen, m_rd;
  logic [1:0]  m_mer;
  logic        m_req;

  function automatic logic [31:0] vec_of(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    logic [31:0] pend, lat, st;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_st = 0; m_en = 0;
      m_ack = 0; m_sen = 0; m_cen = 0; m_rd = 0; m_mer = 0; m_req = 0;
    end else begin
      pend = m_st & m_en;
      if (bus_rd_en) begin
        case (bus_addr[4:2])
          0: m_rd = m_st;    1: m_rd = pend;   2: m_rd = m_en;  3: m_rd = m_ack;
          4: m_rd = m_sen;   5: m_rd = m_cen;  6: m_rd = vec_of(pend);
          default: m_rd = {30'd0, m_mer};
        endcase
      end
      lat = 0;
      if (m_mer[1]) lat = (m_s2 & ~EDGE) | (m_s2 & ~m_prev & EDGE);
      st = m_st;
      m_req = m_mer[0] && (pend != 0);
      if (bus_wr_en) begin
        case (bus_addr[4:2])
          0: if (!m_mer[1]) st = bus_wr_data;
          2: m_en = bus_wr_data;
          3: begin st = st & ~bus_wr_data; m_ack = bus_wr_data; end
          4: begin m_en = m_en | bus_wr_data; m_sen = bus_wr_data; end
          5: begin m_en = m_en & ~bus_wr_data; m_cen = bus_wr_data; end
          7: m_mer = bus_wr_data[1:0];
          default: ;
        endcase
      end
      m_st = st | lat;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", t, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({"R8 req ", tag}, {31'd0, irq_req}, {31'd0, m_req});
      check({"R11 rd ", tag}, bus_rd_data, m_rd);
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(idx * 4); bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 5'(idx * 4); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    tag = "R1";
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check("R1 reset word", v, (i == 6) ? 32'hFFFF_FFFF : 32'h0);
    end
    check("R1 reset req", {31'd0, irq_req}, 32'h0);

    tag = "R8";
    wr(7, 32'hFFFF_FFFF);
    rd(7, v); check("R8 master keeps two bits", v, 32'h3);

    tag = "R7";
    wr(4, 32'h0001_0005);
    wr(5, 32'h0000_0004);
    rd(2, v); check("R7 set then clear enable", v, 32'h0001_0001);
    rd(4, v); check("R7 set-enable readback", v, 32'h0001_0005);
    rd(5, v); check("R7 clear-enable readback", v, 32'h0000_0004);

    tag = "R2";
    irq_in[0] = 1'b1;
    idle(4);
    irq_in[0] = 1'b0;
    idle(4);
    rd(0, v); check("R2 level latched", v, 32'h1);
    check("R8 req raised", {31'd0, irq_req}, 32'h1);
    rd(6, v); check("R5 vector bit0", v, 32'h0);

    tag = "R6";
    wr(3, 32'h1);
    rd(0, v); check("R6 ack clears", v, 32'h0);
    rd(3, v); check("R7 ack readback", v, 32'h1);

    tag = "R3";
    irq_in[16] = 1'b1; idle(1); irq_in[16] = 1'b0;
    idle(5);
    rd(0, v); check("R3 edge held", v, 32'h0001_0000);
    rd(1, v); check("R4 pending", v, 32'h0001_0000);
    rd(6, v); check("R5 vector 16", v, 32'd16);

    tag = "R6 collide level";
    irq_in[0] = 1'b1; idle(4);
    wr(3, 32'h0001_0001);
    rd(0, v); check("R6 latch beats ack", v, 32'h1);
    irq_in[0] = 1'b0; idle(4);
    wr(3, 32'h1);

    tag = "R6 collide edge";
    // Synced rise of bit 17 reaches latch logic on the write's clock edge.
    wr(4, 32'h0002_0000);
    @(negedge clk); irq_in[17] = 1'b1;
    bus_addr = 5'd12; bus_wr_data = 32'h0002_0000;
    @(negedge clk); @(negedge clk);
    bus_wr_en = 1'b1;
    @(negedge clk); bus_wr_en = 1'b0; irq_in[17] = 1'b0;
    rd(0, v); check("R6 edge beats ack", v & 32'h0002_0000, 32'h0002_0000);

    tag = "R4";
    wr(1, 32'hFFFF_FFFF); wr(6, 32'h0);
    rd(1, v); check("R4 pending write ignored", v, 32'h0002_0000);
    rd(6, v); check("R4 vector write ignored", v, 32'd17);

    tag = "R9";
    wr(0, 32'h0000_00A5);
    rd(0, v); check("R9 status write ignored", v, 32'h0002_0000);
    wr(7, 32'h1);
    wr(0, 32'h0000_00A5);
    rd(0, v); check("R9 status write replaces", v, 32'h0000_00A5);

    tag = "R10";
    irq_in = 32'hFFFF_FFFF; idle(5); irq_in = '0; idle(3);
    rd(0, v); check("R10 no latch when off", v, 32'h0000_00A5);
    wr(2, 32'h0); idle(2);
    check("R8 req drops", {31'd0, irq_req}, 32'h0);

    tag = "mix";
    wr(7, 32'h3);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      irq_in = $urandom() & $urandom();
      bus_addr = 5'($urandom_range(0, 7) * 4);
      bus_wr_data = $urandom();
      bus_wr_en = ($urandom_range(0, 3) == 0);
      bus_rd_en = ($urandom_range(0, 1) == 0);
      if (bus_wr_en && bus_addr == 5'd28) bus_wr_data[1:0] = 2'b11;
    end
    @(negedge clk); bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule